// File: doc/BRIEF.md
# Vector memory address generator

This block turns one vector load or store command into a stream of per-element byte addresses. A command carries a base address, an element width, a requested element count, a per-lane mask, a scalar byte stride, a vector of byte offsets and a register count. It also selects one of six access modes: contiguous, strided, ordered offset gather, unordered offset gather, whole-register transfer, and fault-tolerant first access. The generator hands out at most one address per cycle over a valid/ready pair, and each address is tagged with its element number.

A memory side answers each accepted address with a fault flag. In the fault-tolerant mode, a fault on a later element ends the command quietly and reports a shortened element count. A fault on element 0 is reported as a trap instead. When a command finishes, a one-cycle completion pulse carries the final element count. A new command is taken only while the generator is idle.

Top module: `vec_addr_gen`

## Requirements
- R1: In mode 0 (contiguous) and mode 5 (fault-tolerant first), element i has address base + i × 2^sew, where sew code 0/1/2/3 means 1/2/4/8 bytes. Elements are issued in rising order. A requested count above NUM_ELEM is clamped to NUM_ELEM, and the clamped count is reported on completion.
- R2: In mode 1 (strided), element i has address base + i × stride, computed modulo 2^ADDR_W. A stride of 0 gives the same address for every element, and a stride with the top bit set walks downward.
- R3: In mode 2 (ordered gather), element i has address base + off[i], where off[i] is bits [i×ADDR_W +: ADDR_W] of the offset input. Elements are issued in rising element order.
- R4: In mode 3 (unordered gather), addresses are formed as in R3, but the active elements are issued from the highest element number down to 0.
- R5: In every mode except 4, an element whose mask bit is 0 produces no request.
- R6: In mode 4 (whole-register), the generator issues nreg × VLEN_BYTES / 2^sew contiguous addresses from base, one for each element in rising order, and takes no account of the mask or the requested count.
- R7: In mode 5, a fault returned with an accepted address for element k > 0 ends the command with no further requests. The completion then reports count k and no trap.
- R8: In mode 5, a fault returned with element 0 ends the command with the trap flag set and a reported count of 0.
- R9: In modes other than 5, the fault input has no effect: every address is still issued and the full count is reported.
- R10: While a request is valid and not accepted, its address and element number stay unchanged into the next cycle.
- R11: The completion pulse lasts one cycle and is never high together with a valid request. Command-ready is low from acceptance to completion. The pulse comes in the cycle after the final step, where a step is the acceptance of an address, the skip of a masked element, or the acceptance of a faulting address, and each skipped element takes one cycle.
- R12: While reset is high and after it is released, there is no valid request, no completion pulse, and command-ready is high.
- R13: If element step 0 is active, its request becomes valid in the second cycle after the cycle in which the command was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle; command taken on valid and ready |
| cmd_mode | input | 3 | Access mode code (0..5) |
| cmd_sew | input | 2 | Element width code, bytes = 2^code |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_stride | input | ADDR_W | Byte stride for mode 1 |
| cmd_vl | input | VL_W | Requested element count |
| cmd_mask | input | NUM_ELEM | Per-element enable, bit i for element i |
| cmd_index | input | NUM_ELEM×ADDR_W | Byte offsets, element i in bits [i×ADDR_W +: ADDR_W] |
| cmd_nreg | input | NREG_W | Register count for mode 4 |
| req_valid | output | 1 | Address request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Byte address of the element |
| req_elem | output | CNT_W | Element number of the request |
| req_fault | input | 1 | Fault response, sampled with an accepted request |
| done | output | 1 | One-cycle completion pulse |
| done_vl | output | VL_W | Final element count, valid with done |
| done_trap | output | 1 | Element-0 fault in mode 5, valid with done |

## Verification
The command is taken at the first edge. The first address is registered at the next edge, so it can be seen two cycles after the command is offered. Every masked element costs one cycle. The completion pulse follows the last step by exactly one edge, and after a fault it follows the faulting acceptance by one edge. The bench keeps a cycle count for each command, measured at falling edges. From the mode, the mask and the fault position it works out the step number of the last issued element, and from that the exact count at which the pulse must appear. It compares that count, not an upper bound. Ready stalls are inserted every third cycle on some rows, and a stalled request is compared on the next falling edge against the values it showed before.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [2:0] {
    VAG_UNIT      = 3'd0,
    VAG_STRIDED   = 3'd1,
    VAG_IDX_ORD   = 3'd2,
    VAG_IDX_UNORD = 3'd3,
    VAG_WHOLE     = 3'd4,
    VAG_FOF       = 3'd5
  } vag_mode_e;
endpackage

// File: rtl/vag_lane_seq.sv
// Maps the step counter onto an element number and decides whether the
// element is active.
module vag_lane_seq #(
  parameter int NUM_ELEM = 8,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    total,
  input  logic                descending,
  input  logic                use_mask,
  input  logic [NUM_ELEM-1:0] mask,
  output logic [CNT_W-1:0]    lane,
  output logic                finished,
  output logic                active
);
  always_comb begin
    finished = (cnt >= total);
    lane     = descending ? (total - cnt - CNT_W'(1)) : cnt;
    if (!use_mask) active = 1'b1;
    else           active = (lane < CNT_W'(NUM_ELEM)) && mask[lane[IDX_W-1:0]];
  end
endmodule

// File: rtl/vag_addr_calc.sv
// Forms the byte address of one element from the mode and the operands.
module vag_addr_calc
  import vag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_ELEM = 8,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  vag_mode_e                    mode,
  input  logic [1:0]                   sew,
  input  logic [ADDR_W-1:0]            base,
  input  logic [ADDR_W-1:0]            stride,
  input  logic [NUM_ELEM*ADDR_W-1:0]   index,
  input  logic [CNT_W-1:0]             lane,
  output logic [ADDR_W-1:0]            addr
);
  logic [ADDR_W-1:0] off_arr [NUM_ELEM];
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] idx_off;

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_unpack
    assign off_arr[g] = index[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    if (lane < CNT_W'(NUM_ELEM)) idx_off = off_arr[lane[IDX_W-1:0]];
    else                         idx_off = '0;
    case (mode)
      VAG_STRIDED:                offset = stride * ADDR_W'(lane);
      VAG_IDX_ORD, VAG_IDX_UNORD: offset = idx_off;
      default:                    offset = ADDR_W'(lane) << sew;
    endcase
    addr = base + offset;
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_ELEM   = 8,
  parameter int VLEN_BYTES = 16,
  parameter int MAX_NREG   = 8,
  localparam int VL_W      = $clog2(NUM_ELEM + 1),
  localparam int CNT_W     = $clog2(MAX_NREG * VLEN_BYTES + 1),
  localparam int NREG_W    = $clog2(MAX_NREG + 1),
  localparam int IDX_W     = $clog2(NUM_ELEM),
  localparam int PROD_W    = CNT_W + NREG_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [2:0]                  cmd_mode,
  input  logic [1:0]                  cmd_sew,
  input  logic [ADDR_W-1:0]           cmd_base,
  input  logic [ADDR_W-1:0]           cmd_stride,
  input  logic [VL_W-1:0]             cmd_vl,
  input  logic [NUM_ELEM-1:0]         cmd_mask,
  input  logic [NUM_ELEM*ADDR_W-1:0]  cmd_index,
  input  logic [NREG_W-1:0]           cmd_nreg,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [ADDR_W-1:0]           req_addr,
  output logic [CNT_W-1:0]            req_elem,
  input  logic                        req_fault,
  output logic                        done,
  output logic [VL_W-1:0]             done_vl,
  output logic                        done_trap
);
  logic                       busy_q;
  vag_mode_e                  mode_q;
  logic [1:0]                 sew_q;
  logic [ADDR_W-1:0]          base_q, stride_q;
  logic [NUM_ELEM-1:0]        mask_q;
  logic [NUM_ELEM*ADDR_W-1:0] index_q;
  logic [CNT_W-1:0]           total_q, cnt_q;
  logic [VL_W-1:0]            vl_q;
  logic                       req_valid_q, done_q, done_trap_q;
  logic [ADDR_W-1:0]          req_addr_q;
  logic [CNT_W-1:0]           req_elem_q;
  logic [VL_W-1:0]            done_vl_q;

  logic [CNT_W-1:0]  lane;
  logic              finished, active;
  logic [ADDR_W-1:0] next_addr;
  logic [VL_W-1:0]   vl_eff;
  logic [PROD_W-1:0] whole_bytes;
  logic [CNT_W-1:0]  total_d;
  logic              hs, fault_hit, slot;
  vag_mode_e         mode_d;

  assign mode_d      = vag_mode_e'(cmd_mode);
  assign vl_eff      = (cmd_vl > VL_W'(NUM_ELEM)) ? VL_W'(NUM_ELEM) : cmd_vl;
  assign whole_bytes = PROD_W'(cmd_nreg) * PROD_W'(VLEN_BYTES);
  assign total_d     = (mode_d == VAG_WHOLE) ? CNT_W'(whole_bytes >> cmd_sew)
                                             : CNT_W'(vl_eff);

  assign hs        = req_valid_q && req_ready;
  assign fault_hit = hs && (mode_q == VAG_FOF) && req_fault;
  assign slot      = !req_valid_q || req_ready;

  vag_lane_seq #(.NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W)) u_seq (
    .cnt        (cnt_q),
    .total      (total_q),
    .descending (mode_q == VAG_IDX_UNORD),
    .use_mask   (mode_q != VAG_WHOLE),
    .mask       (mask_q),
    .lane       (lane),
    .finished   (finished),
    .active     (active)
  );

  vag_addr_calc #(.ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W)) u_calc (
    .mode   (mode_q),
    .sew    (sew_q),
    .base   (base_q),
    .stride (stride_q),
    .index  (index_q),
    .lane   (lane),
    .addr   (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      mode_q      <= VAG_UNIT;
      sew_q       <= '0;
      base_q      <= '0;
      stride_q    <= '0;
      mask_q      <= '0;
      index_q     <= '0;
      total_q     <= '0;
      cnt_q       <= '0;
      vl_q        <= '0;
      req_valid_q <= 1'b0;
      req_addr_q  <= '0;
      req_elem_q  <= '0;
      done_q      <= 1'b0;
      done_vl_q   <= '0;
      done_trap_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q      <= 1'b1;
          mode_q      <= mode_d;
          sew_q       <= cmd_sew;
          base_q      <= cmd_base;
          stride_q    <= cmd_stride;
          mask_q      <= cmd_mask;
          index_q     <= cmd_index;
          total_q     <= total_d;
          vl_q        <= vl_eff;
          cnt_q       <= '0;
          done_trap_q <= 1'b0;
        end
      end else if (fault_hit) begin
        req_valid_q <= 1'b0;
        busy_q      <= 1'b0;
        done_q      <= 1'b1;
        done_vl_q   <= VL_W'(req_elem_q);
        done_trap_q <= (req_elem_q == '0);
      end else if (slot) begin
        if (finished) begin
          req_valid_q <= 1'b0;
          busy_q      <= 1'b0;
          done_q      <= 1'b1;
          done_vl_q   <= vl_q;
        end else begin
          req_valid_q <= active;
          req_addr_q  <= next_addr;
          req_elem_q  <= lane;
          cnt_q       <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign req_valid = req_valid_q;
  assign req_addr  = req_addr_q;
  assign req_elem  = req_elem_q;
  assign done      = done_q;
  assign done_vl   = done_vl_q;
  assign done_trap = done_trap_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_q && !req_ready |=> req_valid_q && $stable(req_addr_q) && $stable(req_elem_q));

  // R5
  mask_skip_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_q && (mode_q != VAG_WHOLE) |->
      (req_elem_q < CNT_W'(NUM_ELEM)) && mask_q[req_elem_q[IDX_W-1:0]]);

  // R3
  ord_rise_chk: assert property (@(posedge clk) disable iff (rst)
    hs && !fault_hit && (mode_q == VAG_IDX_ORD) |=>
      !req_valid_q || (req_elem_q > $past(req_elem_q)));

  // R4
  unord_fall_chk: assert property (@(posedge clk) disable iff (rst)
    hs && (mode_q == VAG_IDX_UNORD) |=>
      !req_valid_q || (req_elem_q < $past(req_elem_q)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !req_valid_q ##1 !done_q);

  // R7
  fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
    fault_hit |=> done_q && !req_valid_q && (done_vl_q == VL_W'($past(req_elem_q))));
endmodule

// File: tb/vec_addr_gen_tb_top.sv
`timescale 1ns/1ps
module vec_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int NE = 8;

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  sew;
    logic [31:0] base;
    logic [31:0] stride;
    logic [3:0]  vl;
    logic [7:0]  mask;
    logic [3:0]  nreg;
    logic [7:0]  fault_at;
    logic        stall;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 2'd2, 32'h1000, 32'h0,        4'd8,  8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd0, 2'd0, 32'h2001, 32'h0,        4'd5,  8'hFF, 4'd1, 8'hFF, 1'b1},
    '{3'd1, 2'd2, 32'h3000, 32'h40,       4'd6,  8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd1, 2'd2, 32'h3100, 32'h0,        4'd4,  8'hFF, 4'd1, 8'hFF, 1'b1},
    '{3'd2, 2'd2, 32'h4000, 32'h0,        4'd8,  8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd3, 2'd2, 32'h4000, 32'h0,        4'd8,  8'hFF, 4'd1, 8'hFF, 1'b1},
    '{3'd0, 2'd1, 32'h6000, 32'h0,        4'd8,  8'hA6, 4'd1, 8'hFF, 1'b0},
    '{3'd3, 2'd2, 32'h7000, 32'h0,        4'd6,  8'h35, 4'd1, 8'hFF, 1'b0},
    '{3'd4, 2'd2, 32'h5000, 32'h0,        4'd3,  8'h00, 4'd2, 8'hFF, 1'b0},
    '{3'd5, 2'd2, 32'h8000, 32'h0,        4'd8,  8'hFF, 4'd1, 8'd3,  1'b0},
    '{3'd5, 2'd2, 32'h8800, 32'h0,        4'd8,  8'hFF, 4'd1, 8'd0,  1'b0},
    '{3'd1, 2'd3, 32'h9000, 32'h10,       4'd5,  8'hFF, 4'd1, 8'd2,  1'b0},
    '{3'd0, 2'd2, 32'hA000, 32'h0,        4'd0,  8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd0, 2'd2, 32'hB000, 32'h0,        4'd12, 8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd4, 2'd0, 32'hC000, 32'h0,        4'd8,  8'hFF, 4'd1, 8'hFF, 1'b1},
    '{3'd1, 2'd3, 32'hD000, 32'hFFFFFFF8, 4'd4,  8'hFF, 4'd1, 8'hFF, 1'b0},
    '{3'd5, 2'd2, 32'hE000, 32'h0,        4'd8,  8'hF2, 4'd1, 8'd5,  1'b0}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [2:0]      cmd_mode = '0;
  logic [1:0]      cmd_sew = '0;
  logic [AW-1:0]   cmd_base = '0, cmd_stride = '0;
  logic [3:0]      cmd_vl = '0;
  logic [NE-1:0]   cmd_mask = '0;
  logic [NE*AW-1:0] cmd_index = '0;
  logic [3:0]      cmd_nreg = '0;
  logic            req_valid, req_ready = 1'b0, req_fault = 1'b0;
  logic [AW-1:0]   req_addr;
  logic [7:0]      req_elem;
  logic            done, done_trap;
  logic [3:0]      done_vl;

  int checks = 0;
  int failures = 0;
  bit finished_run = 0;

  int          exp_lane [0:127];
  int          exp_step [0:127];
  logic [31:0] exp_addr [0:127];

  always #2 clk = ~clk;

  vec_addr_gen dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_sew(cmd_sew), .cmd_base(cmd_base),
    .cmd_stride(cmd_stride), .cmd_vl(cmd_vl), .cmd_mask(cmd_mask),
    .cmd_index(cmd_index), .cmd_nreg(cmd_nreg), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
    .req_fault(req_fault), .done(done), .done_vl(done_vl), .done_trap(done_trap)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_val(input int i);
    return ((i * 5) % 8) * 32'h20 + 32'h3 * i;
  endfunction

  function automatic logic [31:0] bench_addr(input row_t r, input int ln);
    case (r.mode)
      3'd1:       return r.base + r.stride * ln;
      3'd2, 3'd3: return r.base + idx_val(ln);
      default:    return r.base + (ln << r.sew);
    endcase
  endfunction

  function automatic string row_tag(input row_t r);
    if (r.mode == 3'd4) return "R6";
    if (r.mode == 3'd5 && r.fault_at != 8'hFF) return (r.fault_at == 0) ? "R8" : "R7";
    if (r.fault_at != 8'hFF) return "R9";
    if (r.mask != 8'hFF) return "R5";
    case (r.mode)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic run_row(input row_t r);
    int vle, total, n, exp_vl, t, got, first_valid, last_hs, done_at, exp_done;
    bit whole, faulted, trap, rdy, prev_stall;
    logic [31:0] prev_addr;
    string tg;
    tg = row_tag(r);
    vle = (r.vl > 8) ? 8 : int'(r.vl);
    whole = (r.mode == 3'd4);
    total = whole ? ((int'(r.nreg) * 16) >> r.sew) : vle;
    n = 0;
    for (int k = 0; k < total; k++) begin
      int ln;
      ln = (r.mode == 3'd3) ? total - 1 - k : k;
      if (whole || r.mask[ln]) begin
        exp_lane[n] = ln; exp_step[n] = k; exp_addr[n] = bench_addr(r, ln); n++;
      end
    end
    exp_vl = vle; faulted = 0; trap = 0;
    if (r.mode == 3'd5 && r.fault_at != 8'hFF) begin
      for (int j = 0; j < n; j++) begin
        if (!faulted && exp_lane[j] == int'(r.fault_at)) begin
          n = j + 1; exp_vl = r.fault_at; trap = (r.fault_at == 0); faulted = 1;
        end
      end
    end

    @(negedge clk);
    check(cmd_ready == 1'b1, "R11", "ready when idle", cmd_ready, 1);
    cmd_mode = r.mode; cmd_sew = r.sew; cmd_base = r.base; cmd_stride = r.stride;
    cmd_vl = r.vl; cmd_mask = r.mask; cmd_nreg = r.nreg; cmd_valid = 1'b1;
    t = 0; got = 0; first_valid = -1; last_hs = -1; done_at = -1; prev_stall = 0;
    prev_addr = '0;
    while (t < 600 && done_at < 0) begin
      @(negedge clk);
      t++;
      if (t == 1) begin
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R11", "ready low while busy", cmd_ready, 0);
      end
      if (prev_stall)
        check(req_valid && req_addr == prev_addr, "R10", "held request",
              req_addr, prev_addr);
      if (req_valid && first_valid < 0) first_valid = t;
      rdy = !(r.stall && (t % 3 == 1));
      req_ready = rdy;
      req_fault = req_valid && (r.fault_at != 8'hFF) && (req_elem == r.fault_at);
      if (req_valid && rdy) begin
        if (got < n) begin
          check(req_addr == exp_addr[got], tg, "address", req_addr, exp_addr[got]);
          check(int'(req_elem) == exp_lane[got], tg, "element", req_elem, exp_lane[got]);
        end else begin
          check(1'b0, tg, "extra request", req_elem, 0);
        end
        got++;
        last_hs = t;
      end
      if (done) begin
        done_at = t;
        check(req_valid == 1'b0, "R11", "done with valid", req_valid, 0);
      end
      prev_stall = req_valid && !rdy;
      prev_addr = req_addr;
    end
    req_ready = 1'b0; req_fault = 1'b0;
    if (done_at < 0) begin
      check(1'b0, "R11", "watchdog per command", t, 0);
    end else begin
      check(got == n, tg, "request count", got, n);
      check(int'(done_vl) == exp_vl, tg, "reported count", done_vl, exp_vl);
      check(done_trap == trap, tg, "trap flag", done_trap, trap);
      if (n == 0) exp_done = total + 2;
      else if (faulted) exp_done = last_hs + 1;
      else exp_done = last_hs + 1 + (total - 1 - exp_step[n-1]);
      check(done_at == exp_done, "R11", "done cycle", done_at, exp_done);
      if (n > 0 && exp_step[0] == 0)
        check(first_valid == 2, "R13", "first request cycle", first_valid, 2);
      @(negedge clk);
      check(done == 1'b0, "R11", "done one cycle", done, 0);
      check(cmd_ready == 1'b1, "R11", "ready after done", cmd_ready, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < NE; i++) cmd_index[i*AW +: AW] = idx_val(i);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0 && done == 1'b0, "R12", "outputs in reset",
          {req_valid, done}, 0);
    check(cmd_ready == 1'b1, "R12", "ready in reset", cmd_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(req_valid == 1'b0 && done == 1'b0 && cmd_ready == 1'b1, "R12",
          "state after reset", {req_valid, done, cmd_ready}, 1);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

    // Reset while a command is running (R12)
    @(negedge clk);
    cmd_mode = 3'd0; cmd_sew = 2'd2; cmd_base = 32'h1000; cmd_vl = 4'd8;
    cmd_mask = 8'hFF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(req_valid == 1'b0 && done == 1'b0 && cmd_ready == 1'b1, "R12",
          "reset mid command", {req_valid, done, cmd_ready}, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0 && cmd_ready == 1'b1, "R12", "idle after reset",
          {req_valid, cmd_ready}, 1);

    finished_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule